// File: doc/BRIEF.md
# Fractional M/N Clock Divider

The block derives a slower audio serial clock from a fixed reference, usually 25 MHz with 19.2 MHz as the other choice. Over time the output rate is exactly M/N of the reference rate. A phase accumulator adds an increment on every enabled reference cycle and wraps modulo N. Each wrap is an output event. Because the ratio is rational and not an integer, the spacing between events changes from one cycle to the next by at most one reference period, while the long-run rate stays exact. For example, 441/625 turns 25 MHz into 17.64 MHz, 6/3125 gives 48 kHz and 96/125 gives 19.2 MHz. Programmers load M and N reduced to lowest terms.

Each serial port gets its own instance. M and N arrive as parallel words together with a load strobe. A parameter picks the output shape:

- **Toggle mode:** the accumulator adds 2·M. The output flips on every wrap, which gives a clock with a 50 % average duty cycle at M/N of the reference. This needs 2·M ≤ N.
- **Pulse mode:** the accumulator adds M. The output is a one-reference-cycle pulse on each wrap. This needs M < N.

In both modes the `tick` strobe marks exactly one reference cycle per output period.

Top module: `fracClockDiv`

## Requirements
- R1: During and after synchronous reset, `divClk`, `tick` and `cfgError` are 0, and no configuration counts as loaded, so nothing toggles until a valid load.
- R2: After a valid load, every span of k·N enabled reference edges produces exactly k·M `tick` pulses in both modes.
- R3: Timing in pulse mode (TOGGLE_MODE=0). Number the enabled edges after the load edge t = 1, 2, … `tick` is 1 in the cycle after edge t exactly when floor(t·M/N) > floor((t−1)·M/N), and is 0 otherwise.
- R4: Timing in toggle mode (TOGGLE_MODE=1). After edge t, `divClk` equals floor(2·t·M/N) mod 2. `tick` is 1 only in the cycle after an edge where `divClk` went from 0 to 1.
- R5: In pulse mode, `divClk` carries the same value as `tick` in every cycle.
- R6: A load with M = 0, N = 0, M ≥ N (pulse mode) or 2·M > N (toggle mode) sets `cfgError` to 1 from the load edge on. After that load, `divClk` and `tick` stay 0 until the next valid load.
- R7: A load clears the accumulator and the output level, so the sequence of R3 and R4 restarts at t = 1 after every load, even when the values are unchanged.
- R8: Changes on `mIn` and `nIn` without `loadStrobe` have no effect on the output sequence.
- R9: While `enable` is 0, `tick` is 0 and `divClk` and the accumulator phase hold their values. Enabled edges resume the count t where it stopped.
- R10: A valid load clears `cfgError` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advances the accumulator when high |
| loadStrobe | input | 1 | Captures `mIn`/`nIn` and clears the phase |
| mIn | input | DATA_W | Numerator M |
| nIn | input | DATA_W | Denominator N |
| divClk | output | 1 | Divided clock (toggle mode) or event pulse (pulse mode) |
| tick | output | 1 | One-cycle strobe, one per output period |
| cfgError | output | 1 | Last loaded ratio was invalid |

## Verification
The assertions take three things for granted:

- `loadStrobe` is a single synchronous pulse.
- `mIn` and `nIn` are stable on the edge where it is sampled.
- The accumulator only advances while a configuration that passed the range test is held, so the phase stays below N.

The stimulus drives every input on the falling edge and gives each load exactly one cycle. Its random ratios take N from 2 to 301 and M from 1 to N/2, so both variants accept every random ratio. Invalid ratios are applied only through directed loads, and those loads are followed by checks that the outputs stay quiet.

// File: rtl/fracDivPkg.sv
package fracDivPkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic clearAcc;   // load edge: zero phase and output level
    logic advance;    // enabled cycle with a valid ratio held
  } divCmd_t;

endpackage

// File: rtl/fracDivCtrl.sv
module fracDivCtrl
  import fracDivPkg::*;
#(
  parameter int DATA_W      = 20,
  parameter bit TOGGLE_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              loadStrobe,
  input  logic [DATA_W-1:0] mIn,
  input  logic [DATA_W-1:0] nIn,
  output divCmd_t           cmd,
  output logic [DATA_W-1:0] mCfg,
  output logic [DATA_W-1:0] nCfg,
  output logic              cfgError
);

  localparam int EXT_W = DATA_W + 1;

  logic             ratioOk;
  logic             cfgHeld;
  logic [EXT_W-1:0] mScaled;
  logic [EXT_W-1:0] nWide;

  // Toggle mode steps by 2M, so its ratio limit is half that of pulse mode.
  assign mScaled = TOGGLE_MODE ? {mIn, 1'b0} : {1'b0, mIn};
  assign nWide   = {1'b0, nIn};

  always_comb begin
    ratioOk = (mIn != '0) && (nIn != '0);
    if (TOGGLE_MODE) ratioOk = ratioOk && (mScaled <= nWide);
    else             ratioOk = ratioOk && (mScaled <  nWide);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mCfg     <= '0;
      nCfg     <= '0;
      cfgHeld  <= 1'b0;
      cfgError <= 1'b0;
    end else if (loadStrobe) begin
      mCfg     <= mIn;
      nCfg     <= nIn;
      cfgHeld  <= ratioOk;
      cfgError <= !ratioOk;
    end
  end

  always_comb begin
    cmd.clearAcc = loadStrobe;
    cmd.advance  = !loadStrobe && enable && cfgHeld;
  end

  // Registered ratio only changes on a load edge.
  p_cfg_stable_r8 : assert property (@(posedge clk) disable iff (rst)
    !$past(loadStrobe) |-> ($stable(mCfg) && $stable(nCfg)));

  // An invalid held ratio never advances.
  p_no_run_on_error_r6 : assert property (@(posedge clk) disable iff (rst)
    cfgError |-> !cmd.advance);

endmodule

// File: rtl/fracDivPath.sv
module fracDivPath
  import fracDivPkg::*;
#(
  parameter int DATA_W      = 20,
  parameter bit TOGGLE_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  divCmd_t           cmd,
  input  logic [DATA_W-1:0] mCfg,
  input  logic [DATA_W-1:0] nCfg,
  output logic              divClk,
  output logic              tick
);

  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] phaseAcc;
  logic [SUM_W-1:0]  stepInc;
  logic [SUM_W-1:0]  phaseSum;
  logic [SUM_W-1:0]  wrapped;
  logic              wrapHit;
  logic [DATA_W-1:0] phaseNext;

  assign stepInc  = TOGGLE_MODE ? {mCfg, 1'b0} : {1'b0, mCfg};
  assign phaseSum = {1'b0, phaseAcc} + stepInc;
  assign wrapHit  = phaseSum >= {1'b0, nCfg};
  assign wrapped  = phaseSum - {1'b0, nCfg};

  always_comb begin
    if (wrapHit) phaseNext = wrapped[DATA_W-1:0];
    else         phaseNext = phaseSum[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || cmd.clearAcc) phaseAcc <= '0;
    else if (cmd.advance)    phaseAcc <= phaseNext;
  end

  generate
    if (TOGGLE_MODE) begin : g_toggle
      logic levelQ;
      logic riseQ;
      always_ff @(posedge clk) begin
        if (rst || cmd.clearAcc) begin
          levelQ <= 1'b0;
          riseQ  <= 1'b0;
        end else if (cmd.advance) begin
          if (wrapHit) levelQ <= !levelQ;
          riseQ <= wrapHit && !levelQ;
        end else begin
          riseQ <= 1'b0;
        end
      end
      assign divClk = levelQ;
      assign tick   = riseQ;

      p_tick_on_rise_r4 : assert property (@(posedge clk) disable iff (rst)
        tick |-> (divClk && !$past(divClk)));
    end else begin : g_pulse
      logic pulseQ;
      always_ff @(posedge clk) begin
        if (rst || cmd.clearAcc) pulseQ <= 1'b0;
        else                     pulseQ <= cmd.advance && wrapHit;
      end
      assign divClk = pulseQ;
      assign tick   = pulseQ;
    end
  endgenerate

  // Phase always below the modulus whenever it is stepped.
  p_acc_in_range_r2 : assert property (@(posedge clk) disable iff (rst)
    cmd.advance |-> (phaseAcc < nCfg));

  // A tick only follows a stepped cycle.
  p_tick_needs_run_r9 : assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(cmd.advance));

endmodule

// File: rtl/fracClockDiv.sv
module fracClockDiv
  import fracDivPkg::*;
#(
  parameter int DATA_W      = 20,
  parameter bit TOGGLE_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              loadStrobe,
  input  logic [DATA_W-1:0] mIn,
  input  logic [DATA_W-1:0] nIn,
  output logic              divClk,
  output logic              tick,
  output logic              cfgError
);

  divCmd_t           cmd;
  logic [DATA_W-1:0] mCfg;
  logic [DATA_W-1:0] nCfg;

  fracDivCtrl #(.DATA_W(DATA_W), .TOGGLE_MODE(TOGGLE_MODE)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .loadStrobe(loadStrobe),
    .mIn(mIn), .nIn(nIn), .cmd(cmd), .mCfg(mCfg), .nCfg(nCfg),
    .cfgError(cfgError)
  );

  fracDivPath #(.DATA_W(DATA_W), .TOGGLE_MODE(TOGGLE_MODE)) u_path (
    .clk(clk), .rst(rst), .cmd(cmd), .mCfg(mCfg), .nCfg(nCfg),
    .divClk(divClk), .tick(tick)
  );

  p_zero_load_flags_r6 : assert property (@(posedge clk) disable iff (rst)
    (loadStrobe && (mIn == '0 || nIn == '0)) |=> cfgError);

  p_err_quiet_r6 : assert property (@(posedge clk) disable iff (rst)
    cfgError |-> (!divClk && !tick));

  p_load_clears_r7 : assert property (@(posedge clk) disable iff (rst)
    $past(loadStrobe) |-> !tick);

endmodule

// File: tb/tb_fracClockDiv.sv
module tb_fracClockDiv;

  localparam int CLK_PERIOD = 10;
  localparam int W = 20;

  logic clk = 1'b0;
  logic rst, enable, loadStrobe;
  logic [W-1:0] mIn, nIn;
  logic togClk, togTick, togErr, pulClk, pulTick, pulErr;

  int checks = 0;
  int fails  = 0;
  longint t = 0;
  longint mCur = 0, nCur = 0;
  bit okTog = 0, okPul = 0, errTog = 0, errPul = 0;
  int mism = 0;
  logic [5:0] firstAct, firstExp;
  longint firstT;
  int tickTog = 0, tickPul = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracClockDiv #(.DATA_W(W), .TOGGLE_MODE(1'b1)) dut (
    .clk(clk), .rst(rst), .enable(enable), .loadStrobe(loadStrobe),
    .mIn(mIn), .nIn(nIn), .divClk(togClk), .tick(togTick), .cfgError(togErr));

  fracClockDiv #(.DATA_W(W), .TOGGLE_MODE(1'b0)) dutPulse (
    .clk(clk), .rst(rst), .enable(enable), .loadStrobe(loadStrobe),
    .mIn(mIn), .nIn(nIn), .divClk(pulClk), .tick(pulTick), .cfgError(pulErr));

  function automatic bit eventAt(longint k, longint m, longint n);
    return ((k * m) / n) != (((k - 1) * m) / n);
  endfunction

  function automatic bit levelAt(longint k, longint m, longint n);
    if (k <= 0) return 1'b0;
    return (((k * 2 * m) / n) % 2) == 1;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Advance cnt clock edges, predicting every output after each edge.
  task automatic cycles(int cnt);
    for (int i = 0; i < cnt; i++) begin
      bit adv;
      logic [5:0] act, exp;
      @(posedge clk);
      adv = 1'b0;
      if (rst) begin
        t = 0; okTog = 0; okPul = 0; errTog = 0; errPul = 0;
      end else if (loadStrobe) begin
        t = 0; mCur = mIn; nCur = nIn;
        okPul  = (mIn != 0) && (nIn != 0) && (mCur < nCur);
        okTog  = (mIn != 0) && (nIn != 0) && (2 * mCur <= nCur);
        errTog = !okTog; errPul = !okPul;
      end else if (enable && (okTog || okPul)) begin
        t++; adv = 1'b1;
      end
      #1;
      exp[5] = okTog && levelAt(t, mCur, nCur);
      exp[4] = okTog && adv && levelAt(t, mCur, nCur) && !levelAt(t - 1, mCur, nCur);
      exp[3] = errTog;
      exp[2] = okPul && adv && eventAt(t, mCur, nCur);
      exp[1] = exp[2];
      exp[0] = errPul;
      act = {togClk, togTick, togErr, pulClk, pulTick, pulErr};
      if (act !== exp) begin
        if (mism == 0) begin firstAct = act; firstExp = exp; firstT = t; end
        mism++;
      end
      tickTog += int'(togTick);
      tickPul += int'(pulTick);
    end
  endtask

  task automatic endPhase(string req, string name);
    check(mism == 0, req, $sformatf("%s output vector {tClk,tTick,tErr,pClk,pTick,pErr} at t=%0d", name, firstT),
          longint'(firstAct), longint'(firstExp));
    mism = 0;
  endtask

  task automatic load(longint m, longint n);
    @(negedge clk);
    mIn = W'(m); nIn = W'(n); loadStrobe = 1'b1;
    cycles(1);
    @(negedge clk);
    loadStrobe = 1'b0;
    tickTog = 0; tickPul = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seedInit;
    rst = 1'b1; enable = 1'b0; loadStrobe = 1'b0; mIn = '0; nIn = '0;
    seedInit = $urandom(32'd20240611);
    cycles(4);
    @(negedge clk); rst = 1'b0;
    cycles(1);
    // R1 reset state
    check({togClk, togTick, togErr, pulClk, pulTick, pulErr} == 6'b0, "R1", "outputs after reset",
          longint'({togClk, togTick, togErr, pulClk, pulTick, pulErr}), 0);
    @(negedge clk); enable = 1'b1;
    cycles(6);
    endPhase("R1", "enabled with nothing loaded");

    // 441/625: pulse valid, toggle invalid (2M > N)
    load(441, 625);
    check(togErr == 1'b1, "R6", "toggle error for 441/625", togErr, 1);
    check(pulErr == 1'b0, "R10", "pulse error for 441/625", pulErr, 0);
    cycles(1250);
    check(tickPul == 882, "R2", "pulse ticks over 2N at 441/625", tickPul, 882);
    check(tickTog == 0, "R6", "toggle ticks while invalid", tickTog, 0);
    endPhase("R3", "pulse sequence 441/625");

    // 6/3125: both valid, 48 kHz case
    load(6, 3125);
    check(togErr == 1'b0, "R10", "toggle error cleared by valid load", togErr, 0);
    cycles(3125);
    check(tickTog == 6, "R2", "toggle ticks over N at 6/3125", tickTog, 6);
    check(tickPul == 6, "R2", "pulse ticks over N at 6/3125", tickPul, 6);
    endPhase("R4", "toggle and pulse sequence 6/3125");

    // 96/125: high ratio, pulse gets back-to-back ticks
    load(96, 125);
    cycles(250);
    check(tickPul == 192, "R2", "pulse ticks over 2N at 96/125", tickPul, 192);
    check(togErr == 1'b1, "R6", "toggle error for 96/125", togErr, 1);
    endPhase("R5", "pulse output equals tick 96/125");

    // Invalid values in pulse mode
    load(0, 5);
    check(pulErr == 1'b1, "R6", "pulse error M=0", pulErr, 1);
    cycles(8);
    load(5, 0);
    check(pulErr == 1'b1, "R6", "pulse error N=0", pulErr, 1);
    cycles(8);
    load(7, 7);
    check(pulErr == 1'b1, "R6", "pulse error M=N", pulErr, 1);
    cycles(8);
    endPhase("R6", "outputs quiet after invalid loads");

    // R8: input change without load ignored
    load(3, 10);
    cycles(7);
    @(negedge clk); mIn = W'(9); nIn = W'(11);
    cycles(23);
    check(tickPul == 9, "R8", "pulse ticks with unloaded new inputs", tickPul, 9);
    check(tickTog == 9, "R8", "toggle ticks with unloaded new inputs", tickTog, 9);
    endPhase("R8", "sequence unchanged by unloaded inputs");

    // R7: reload mid-run restarts phase
    load(3, 10);
    cycles(4);
    load(3, 10);
    cycles(10);
    check(tickPul == 3, "R7", "pulse ticks after reload", tickPul, 3);
    endPhase("R7", "sequence restart after reload");

    // R9: enable low pauses
    load(5, 12);
    cycles(5);
    @(negedge clk); enable = 1'b0;
    tickTog = 0; tickPul = 0;
    cycles(9);
    check(tickTog + tickPul == 0, "R9", "ticks while disabled", tickTog + tickPul, 0);
    @(negedge clk); enable = 1'b1;
    cycles(19);
    check(tickPul == 8, "R9", "pulse ticks over resumed span (24 total = 10)", tickPul, 8);
    endPhase("R9", "phase held across disable");

    // Large denominator, partial window
    load(441, 250000);
    cycles(3000);
    check(tickPul == 5, "R3", "pulse ticks in 3000 cycles at 441/250000", tickPul, 5);
    endPhase("R3", "sequence 441/250000");

    // Random valid ratios
    for (int k = 0; k < 8; k++) begin
      longint n, m;
      n = 2 + ($urandom % 300);
      m = 1 + ($urandom % (n / 2));
      load(m, n);
      cycles(int'(2 * n));
      check(tickTog == 2 * m, "R2", $sformatf("random toggle ticks %0d/%0d", m, n), tickTog, 2 * m);
      check(tickPul == 2 * m, "R2", $sformatf("random pulse ticks %0d/%0d", m, n), tickPul, 2 * m);
      endPhase("R4", $sformatf("random sequence %0d/%0d", m, n));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule